// File: doc/BRIEF.md
# Transponder ID Frame Generator

This block produces the serial identification stream of a read-only RFID tag. It takes a 40-bit identifier and forms a 64-bit frame from it. The frame holds a run of nine ones, ten rows of four data bits each followed by a row parity bit, a nibble of column parity and a closing zero. The frame goes out one bit per strobe from an external bit-rate divider. It repeats with no gap for as long as the enable input is high. A downstream line coder turns the bit stream into modulation.

The parity mode select picks one of two schemes. The first uses even parity on every row. The second uses odd parity on the first two rows and even parity on the rest. The identifier and the mode are both captured at a frame boundary, so one frame never mixes old and new content. The start-of-frame flag marks the cycles in which the first header bit is on the output.

Top module: `tid_frame_gen`

## Requirements
- R1: The frame is 64 bit positions long, and sof_o rises once every 64 strobes while enable stays high.
- R2: Positions 0 to 8 of the frame are all 1.
- R3: Positions 9 to 58 hold ten rows of 5 bits. Row r (r = 0..9) carries id_i[39-4r -: 4] with its bit 3 sent first, then the row parity bit at position 13+5r.
- R4: With par_mode_i = 0, every row parity bit makes the five bits of its row even in ones.
- R5: Positions 59 to 62 hold column parity for data bit 3, 2, 1 and 0 in that order. Each is even parity over that bit in all ten data nibbles, parity bits excluded, in both modes.
- R6: Position 63, the stop bit, is always 0.
- R7: The strobe after position 63 returns the output to position 0 directly, with no idle bit.
- R8: The position moves by exactly one on each cycle in which adv_i is high and enable is high. It holds when adv_i is low.
- R9: sof_o is 1 exactly when enable is high, reset is released and position 0 is on the output.
- R10: With par_mode_i = 1, rows 0 and 1 use odd parity (row of five has an odd count of ones) and rows 2 to 9 use even parity.
- R11: A change of id_i or par_mode_i during a frame does not alter that frame. It appears from the next position 0 onward.
- R12: While rst_ni is low or en_i is low, bit_o and sof_o are 0. When enable returns, the output restarts at position 0 with the identifier present while it was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low holds the output at 0 and the position at 0 |
| id_i | input | 40 | Identifier; bits 39:36 form the first row |
| par_mode_i | input | 1 | 0: all rows even; 1: first two rows odd |
| adv_i | input | 1 | One-cycle strobe that moves to the next bit |
| bit_o | output | 1 | Serial frame bit |
| sof_o | output | 1 | High while frame position 0 is on the output |

## Verification
bit_o and sof_o are combinational from the registered position. They follow the enable and reset inputs in the same cycle, and they show the new position one clock edge after a strobe is sampled. An identifier or mode change shows up only after the edge that carries the final strobe of the frame. The bench drives each input on a falling edge and reads the outputs on the next falling edge. Every strobe is therefore read after exactly one rising edge, and disable effects are read in the cycle they are applied. Each frame is captured in full before it is compared with a frame the bench builds itself.

// File: rtl/tid_pkg.sv
package tid_pkg;
  function automatic int frame_len(input int hdr, input int rows, input int cols);
    return hdr + rows * (cols + 1) + cols + 1;
  endfunction
endpackage

// File: rtl/tid_parity.sv
module tid_parity #(
  parameter int ROWS     = 10,
  parameter int COLS     = 4,
  parameter int ODD_ROWS = 2,
  localparam int ID_W    = ROWS * COLS
) (
  input  logic [ID_W-1:0] id_i,
  input  logic            odd_mode_i,
  output logic [ROWS-1:0] row_par_o,
  output logic [COLS-1:0] col_par_o
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    localparam bit FLIP = (r < ODD_ROWS);
    assign row_par_o[r] = (^id_i[ID_W-1-COLS*r -: COLS]) ^ (odd_mode_i & FLIP);
  end

  always_comb begin
    col_par_o = '0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        col_par_o[c] ^= id_i[ID_W-COLS*(r+1)+c];
  end
endmodule

// File: rtl/tid_frame_asm.sv
module tid_frame_asm #(
  parameter int HDR       = 9,
  parameter int ROWS      = 10,
  parameter int COLS      = 4,
  localparam int ID_W     = ROWS * COLS,
  localparam int FRAME_W  = tid_pkg::frame_len(HDR, ROWS, COLS),
  localparam int COL_BASE = HDR + ROWS * (COLS + 1)
) (
  input  logic [ID_W-1:0]    id_i,
  input  logic [ROWS-1:0]    row_par_i,
  input  logic [COLS-1:0]    col_par_i,
  output logic [FRAME_W-1:0] frame_o   // index = send order
);
  for (genvar h = 0; h < HDR; h++) begin : g_hdr
    assign frame_o[h] = 1'b1;
  end
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    localparam int BASE = HDR + r * (COLS + 1);
    for (genvar j = 0; j < COLS; j++) begin : g_bit
      assign frame_o[BASE+j] = id_i[ID_W-1-COLS*r-j];
    end
    assign frame_o[BASE+COLS] = row_par_i[r];
  end
  for (genvar j = 0; j < COLS; j++) begin : g_col
    assign frame_o[COL_BASE+j] = col_par_i[COLS-1-j];
  end
  assign frame_o[FRAME_W-1] = 1'b0;
endmodule

// File: rtl/tid_pos_ctr.sv
module tid_pos_ctr #(
  parameter int  LEN = 64,
  localparam int PW  = $clog2(LEN)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          adv_i,
  output logic [PW-1:0] pos_o,
  output logic          wrap_o
);
  localparam logic [PW-1:0] LAST = PW'(LEN - 1);

  assign wrap_o = en_i & adv_i & (pos_o == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pos_o <= '0;
    else if (!en_i)  pos_o <= '0;
    else if (wrap_o) pos_o <= '0;
    else if (adv_i)  pos_o <= pos_o + 1'b1;
  end
endmodule

// File: rtl/tid_frame_gen.sv
module tid_frame_gen #(
  parameter int  HDR      = 9,
  parameter int  ROWS     = 10,
  parameter int  COLS     = 4,
  parameter int  ODD_ROWS = 2,
  localparam int ID_W     = ROWS * COLS,
  localparam int FRAME_W  = tid_pkg::frame_len(HDR, ROWS, COLS),
  localparam int PW       = $clog2(FRAME_W)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [ID_W-1:0] id_i,
  input  logic            par_mode_i,
  input  logic            adv_i,
  output logic            bit_o,
  output logic            sof_o
);
  logic [ID_W-1:0]    id_q;
  logic               mode_q;
  logic [PW-1:0]      pos_q;
  logic               wrap;
  logic [ROWS-1:0]    row_par;
  logic [COLS-1:0]    col_par;
  logic [FRAME_W-1:0] frame;

  tid_pos_ctr #(.LEN(FRAME_W)) u_pos (
    .clk_i, .rst_ni, .en_i, .adv_i,
    .pos_o (pos_q),
    .wrap_o(wrap)
  );

  // content captured only at a frame boundary or while idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_q   <= '0;
      mode_q <= 1'b0;
    end else if (!en_i || wrap) begin
      id_q   <= id_i;
      mode_q <= par_mode_i;
    end
  end

  tid_parity #(.ROWS(ROWS), .COLS(COLS), .ODD_ROWS(ODD_ROWS)) u_par (
    .id_i      (id_q),
    .odd_mode_i(mode_q),
    .row_par_o (row_par),
    .col_par_o (col_par)
  );

  tid_frame_asm #(.HDR(HDR), .ROWS(ROWS), .COLS(COLS)) u_asm (
    .id_i     (id_q),
    .row_par_i(row_par),
    .col_par_i(col_par),
    .frame_o  (frame)
  );

  logic live;
  assign live  = rst_ni & en_i;
  assign bit_o = live & frame[pos_q];
  assign sof_o = live & (pos_q == '0);
endmodule

// File: rtl/tid_frame_chk.sv
module tid_frame_chk #(
  parameter int  ID_W    = 40,
  parameter int  FRAME_W = 64,
  localparam int PW      = $clog2(FRAME_W)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            en_i,
  input logic            adv_i,
  input logic            bit_o,
  input logic            sof_o,
  input logic [PW-1:0]   pos_q,
  input logic [ID_W-1:0] id_q
);
  localparam logic [PW-1:0] LAST = PW'(FRAME_W - 1);

  p_stop_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_q == LAST) |-> !bit_o);

  p_header_one_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && pos_q < PW'(9)) |-> bit_o);

  p_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && adv_i && pos_q == LAST) |=> (pos_q == '0));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !adv_i) |=> $stable(pos_q));

  p_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && adv_i && pos_q != LAST) |=> (pos_q == $past(pos_q) + 1'b1));

  p_sof_hdr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> bit_o);

  p_idle_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!bit_o && !sof_o));

  p_idle_pos_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (pos_q == '0));

  p_id_frozen_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !(adv_i && pos_q == LAST)) |=> $stable(id_q));
endmodule

bind tid_frame_gen tid_frame_chk #(.ID_W(ID_W), .FRAME_W(FRAME_W)) u_chk (
  .clk_i, .rst_ni, .en_i, .adv_i, .bit_o, .sof_o, .pos_q, .id_q
);

// File: tb/tid_frame_gen_tb.sv
module tid_frame_gen_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0;
  logic [39:0] id_i = '0;
  logic par_mode_i = 1'b0;
  logic adv_i = 1'b0;
  logic bit_o, sof_o;
  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  tid_frame_gen u_dut (
    .clk_i(clk), .rst_ni, .en_i, .id_i, .par_mode_i, .adv_i, .bit_o, .sof_o
  );

  // {mode, id}
  localparam logic [40:0] VEC [6] = '{
    {1'b0, 40'h00_0000_0000},
    {1'b0, 40'hFF_FFFF_FFFF},
    {1'b0, 40'h01_2345_6789},
    {1'b1, 40'hA5_A5A5_A5A5},
    {1'b1, 40'h00_0000_0000},
    {1'b1, 40'h80_0000_0001}
  };

  function automatic logic [63:0] model(input logic [39:0] id, input logic m);
    logic [63:0] f;
    logic [3:0]  col;
    logic [3:0]  nib;
    int k;
    f = '0; col = '0; k = 0;
    for (int h = 0; h < 9; h++) begin f[k] = 1'b1; k++; end
    for (int r = 0; r < 10; r++) begin
      nib = id[39-4*r -: 4];
      for (int j = 3; j >= 0; j--) begin f[k] = nib[j]; k++; end
      f[k] = (^nib) ^ (m && r < 2);
      k++;
      col ^= nib;
    end
    for (int j = 3; j >= 0; j--) begin f[k] = col[j]; k++; end
    f[63] = 1'b0;
    return f;
  endfunction

  function automatic logic [63:0] mask_of(input int kind);
    logic [63:0] mk = '0;
    for (int k = 0; k < 64; k++) begin
      case (kind)
        0: mk[k] = (k < 9);
        1: mk[k] = (k >= 9 && k < 59 && (k - 9) % 5 != 4);
        2: mk[k] = (k >= 9 && k < 59 && (k - 9) % 5 == 4);
        3: mk[k] = (k >= 59 && k < 63);
        default: mk[k] = (k == 63);
      endcase
    end
    return mk;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic adv_once();
    @(negedge clk) adv_i = 1'b1;
    @(negedge clk) adv_i = 1'b0;
  endtask

  task automatic load_idle(input logic [39:0] id, input logic m);
    @(negedge clk);
    en_i = 1'b0; id_i = id; par_mode_i = m;
    @(negedge clk);
    en_i = 1'b1;
    #1;
  endtask

  // captures one frame from position 0; optionally swaps inputs at chg_at
  task automatic capture(output logic [63:0] c, input int chg_at,
                         input logic [39:0] nid, input logic nm);
    c = '0;
    c[0] = bit_o;
    for (int k = 1; k < 64; k++) begin
      adv_once();
      c[k] = bit_o;
      if (k == 1) check("R9 sof low off pos 0", {63'd0, sof_o}, 64'd0);
      if (k == chg_at) begin id_i = nid; par_mode_i = nm; end
    end
    adv_once();
    check("R7 wrap to header", {62'd0, sof_o, bit_o}, 64'd3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_err);
    $finish;
  end

  initial begin
    logic [63:0] cap, exp;
    en_i = 1'b1;
    #2;
    check("R12 reset quiet", {62'd0, bit_o, sof_o}, 64'd0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    en_i = 1'b0;

    // vector table
    foreach (VEC[i]) begin
      load_idle(VEC[i][39:0], VEC[i][40]);
      check("R9 sof at start", {63'd0, sof_o}, 64'd1);
      capture(cap, -1, '0, 1'b0);
      exp = model(VEC[i][39:0], VEC[i][40]);
      check("R2 header", cap & mask_of(0), exp & mask_of(0));
      check("R3 data order", cap & mask_of(1), exp & mask_of(1));
      check(VEC[i][40] ? "R10 alt row parity" : "R4 even row parity",
            cap & mask_of(2), exp & mask_of(2));
      check("R5 column parity", cap & mask_of(3), exp & mask_of(3));
      check("R6 stop bit", cap & mask_of(4), 64'd0);
      check("R1 full frame", cap, exp);
    end

    // R11: change mid-frame, applies at next frame
    load_idle(40'h13_579B_DF02, 1'b0);
    capture(cap, 20, 40'hFE_DCBA_9876, 1'b1);
    check("R11 old frame kept", cap, model(40'h13_579B_DF02, 1'b0));
    capture(cap, -1, '0, 1'b0);
    check("R11 new frame used", cap, model(40'hFE_DCBA_9876, 1'b1));

    // R8: no strobe -> position holds
    repeat (6) @(negedge clk);
    check("R8 hold at pos 0", {62'd0, sof_o, bit_o}, 64'd3);
    for (int k = 0; k < 9; k++) adv_once();
    repeat (5) @(negedge clk);
    check("R8 hold at pos 9", {62'd0, sof_o, bit_o}, {62'd0, 1'b0, model(id_i, par_mode_i)[9]});

    // R12: disable mid-frame
    for (int k = 0; k < 20; k++) adv_once();
    en_i = 1'b0;
    #1;
    check("R12 disabled quiet", {62'd0, bit_o, sof_o}, 64'd0);
    id_i = 40'h00_0000_000F;
    par_mode_i = 1'b0;
    @(negedge clk);
    en_i = 1'b1;
    #1;
    check("R12 restart pos 0", {62'd0, sof_o, bit_o}, 64'd3);
    capture(cap, -1, '0, 1'b0);
    check("R12 idle id taken", cap, model(40'h00_0000_000F, 1'b0));

    // R1: sof period of 64 strobes
    begin
      int cnt = 0;
      for (int k = 0; k < 128; k++) begin adv_once(); cnt += sof_o; end
      check("R1 sof count", 64'(cnt), 64'd2);
    end

    // R12: reset mid-frame
    for (int k = 0; k < 30; k++) adv_once();
    rst_ni = 1'b0;
    #1;
    check("R12 reset forces 0", {62'd0, bit_o, sof_o}, 64'd0);
    @(negedge clk) rst_ni = 1'b1;
    #1;
    check("R12 reset back to pos 0", {63'd0, sof_o}, 64'd1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule